// File: doc/BRIEF.md
# Deep Sleep Power State Controller

This block follows the power state of one codec function group and adds two sleep levels below D3cold, called D4 and D5 here. Software arms either level ahead of time by writing a two-bit control register through a set verb. The level is taken only when the standard power-state verb then asks for D3cold. If both arm bits are set, D5 wins. D4 removes the link responder from the D3cold power budget, so the codec stops answering commands. D5 also switches off the GPIO pins, the reference amplifier and the headphone amplifiers.

Once in D4 or D5 the link is deaf, so no command can bring the block back. The only exits are a synchronous power-on reset or a rising edge on the link reset input. Either exit lands the block in D3cold with both arm bits cleared. The enable outputs are registered from the state, so the power-down controls never glitch.

Top module: `deep_pwr_ctl`

## Requirements
- R1: A get command (verb FD8h) addressed to node 01h in a non-deep state answers one cycle later with rsp_valid high, the two arm bits in rsp_data[1:0] and zero in rsp_data[31:2]. No other command raises rsp_valid.
- R2: A set command (verb 7D8h) to node 01h in a non-deep state loads payload[1:0] into the arm bits (bit 0 arms D4, bit 1 arms D5) and ignores payload[7:2]. Commands carrying any other node id change nothing.
- R3: The power-state command (verb 705h) to node 01h with payload 0, 1, 2, 3 or 4 moves pwr_state to that value on the next clock edge. The encoding is D0=0, D1=1, D2=2, D3=3, D3cold=4, D4=5, D5=6. Payload values above 4 are ignored.
- R4: A D3cold request while arm bit 1 is set enters D5 (pwr_state 6), whatever the value of arm bit 0.
- R5: A D3cold request with only arm bit 0 set enters D4 (pwr_state 5). With no arm bit set it enters plain D3cold (4).
- R6: In D4 or D5, every command is ignored: the state and the arm bits stay as they are and rsp_valid stays low.
- R7: A rising edge on link_rst_in forces pwr_state to D3cold and clears both arm bits on the clock edge that first samples it high. Holding the input high has no further effect.
- R8: While rst is high the block sets pwr_state to D3cold, clears the arm bits, drops rsp_valid and drives all four enables high.
- R9: The enables follow the state one clock later. In D4 only en_link is low. In D5 all four enables are low. In every other state all four are high.
- R10: The arm bits are sampled only when the D3cold request is accepted. Writing them while already in D3cold leaves the state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| link_rst_in | input | 1 | Link reset level; its rising edge is an exit event |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_nid | input | 8 | Target node id |
| cmd_verb | input | 12 | 12-bit verb code |
| cmd_payload | input | 8 | 8-bit verb payload |
| rsp_valid | output | 1 | Response present |
| rsp_data | output | 32 | Response word |
| pwr_state | output | 3 | Current power state code |
| en_link | output | 1 | Link responder enable |
| en_gpio | output | 1 | GPIO pin enable |
| en_vref_amp | output | 1 | Reference amplifier enable |
| en_hp_amp | output | 1 | Headphone amplifier enable |

## Verification
The assertions assume that power-on reset is sampled from the first clock edge. They also assume that no command arrives in the same cycle as a link reset rising edge, because the edge takes priority there and drops the command. The stimulus keeps to this rule by driving link reset pulses only from a dedicated task while cmd_valid is low. That task raises the input, holds it for two cycles and lowers it before the next command. Random commands mix valid verbs, stray node ids and payloads above 4, so the deep states are entered often and then left only through these pulses or a directed power-on reset.

// File: rtl/dpc_pkg.sv
package dpc_pkg;
  typedef enum logic [2:0] {
    PS_D0     = 3'd0,
    PS_D1     = 3'd1,
    PS_D2     = 3'd2,
    PS_D3     = 3'd3,
    PS_D3COLD = 3'd4,
    PS_D4     = 3'd5,
    PS_D5     = 3'd6
  } pstate_t;

  localparam int VERB_W = 12;
  localparam int PAY_W  = 8;
  localparam int ARM_W  = 2;

  localparam logic [VERB_W-1:0] VERB_SET_PWR  = 12'h705;
  localparam logic [VERB_W-1:0] VERB_SET_DEEP = 12'h7D8;
  localparam logic [VERB_W-1:0] VERB_GET_DEEP = 12'hFD8;

  // Enable vector order: {link, gpio, vref_amp, hp_amp}
  localparam int EN_W = 4;

  function automatic logic is_deep(pstate_t s);
    return (s == PS_D4) || (s == PS_D5);
  endfunction

  function automatic logic [EN_W-1:0] en_mask(pstate_t s);
    case (s)
      PS_D4:   return 4'b0111;
      PS_D5:   return 4'b0000;
      default: return 4'b1111;
    endcase
  endfunction
endpackage

// File: rtl/dpc_cmd_decode.sv
module dpc_cmd_decode
  import dpc_pkg::*;
#(
  parameter int                 NID_W   = 8,
  parameter logic [NID_W-1:0]   NODE_ID = 8'h01
) (
  input  logic              cmd_valid,
  input  logic [NID_W-1:0]  cmd_nid,
  input  logic [VERB_W-1:0] cmd_verb,
  input  logic [PAY_W-1:0]  cmd_payload,
  input  logic              block,
  output logic              wr_arm,
  output logic              rd_arm,
  output logic              pwr_req,
  output pstate_t           pwr_target
);
  localparam logic [PAY_W-1:0] MAX_PS = PAY_W'(4);

  logic hit;

  always_comb begin
    hit        = cmd_valid && !block && (cmd_nid == NODE_ID);
    wr_arm     = hit && (cmd_verb == VERB_SET_DEEP);
    rd_arm     = hit && (cmd_verb == VERB_GET_DEEP);
    pwr_req    = hit && (cmd_verb == VERB_SET_PWR) && (cmd_payload <= MAX_PS);
    pwr_target = pstate_t'(cmd_payload[2:0]);
  end
endmodule

// File: rtl/dpc_arm_reg.sv
module dpc_arm_reg
  import dpc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             wr,
  input  logic [ARM_W-1:0] wdata,
  output logic [ARM_W-1:0] arm_q
);
  always_ff @(posedge clk) begin
    if (rst || clr) arm_q <= '0;
    else if (wr)    arm_q <= wdata;
  end
endmodule

// File: rtl/dpc_state_fsm.sv
module dpc_state_fsm
  import dpc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             pwr_req,
  input  pstate_t          pwr_target,
  input  logic [ARM_W-1:0] arm,
  output pstate_t          state_q
);
  pstate_t nxt;

  always_comb begin
    nxt = state_q;
    if (pwr_req) begin
      if (pwr_target == PS_D3COLD) begin
        if (arm[1])      nxt = PS_D5;
        else if (arm[0]) nxt = PS_D4;
        else             nxt = PS_D3COLD;
      end else begin
        nxt = pwr_target;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) state_q <= PS_D3COLD;
    else            state_q <= nxt;
  end
endmodule

// File: rtl/dpc_out_gate.sv
module dpc_out_gate
  import dpc_pkg::*;
#(
  parameter int RSP_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  pstate_t          state,
  input  logic             rd_arm,
  input  logic [ARM_W-1:0] arm,
  output logic [EN_W-1:0]  en_q,
  output logic             rsp_valid,
  output logic [RSP_W-1:0] rsp_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q      <= en_mask(PS_D3COLD);
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      en_q      <= en_mask(state);
      rsp_valid <= rd_arm;
      if (rd_arm) rsp_data <= {{(RSP_W-ARM_W){1'b0}}, arm};
    end
  end
endmodule

// File: rtl/deep_pwr_ctl.sv
module deep_pwr_ctl
  import dpc_pkg::*;
#(
  parameter int               NID_W   = 8,
  parameter logic [NID_W-1:0] NODE_ID = 8'h01,
  parameter int               RSP_W   = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              link_rst_in,
  input  logic              cmd_valid,
  input  logic [NID_W-1:0]  cmd_nid,
  input  logic [11:0]       cmd_verb,
  input  logic [7:0]        cmd_payload,
  output logic              rsp_valid,
  output logic [RSP_W-1:0]  rsp_data,
  output logic [2:0]        pwr_state,
  output logic              en_link,
  output logic              en_gpio,
  output logic              en_vref_amp,
  output logic              en_hp_amp
);
  logic             link_q;
  logic             link_edge;
  logic             wr_arm, rd_arm, pwr_req;
  pstate_t          pwr_target;
  pstate_t          state_q;
  logic [ARM_W-1:0] arm_q;
  logic [EN_W-1:0]  en_q;

  always_ff @(posedge clk) begin
    if (rst) link_q <= 1'b0;
    else     link_q <= link_rst_in;
  end
  assign link_edge = link_rst_in && !link_q;

  dpc_cmd_decode #(.NID_W(NID_W), .NODE_ID(NODE_ID)) u_dec (
    .cmd_valid  (cmd_valid),
    .cmd_nid    (cmd_nid),
    .cmd_verb   (cmd_verb),
    .cmd_payload(cmd_payload),
    .block      (is_deep(state_q) || link_edge),
    .wr_arm     (wr_arm),
    .rd_arm     (rd_arm),
    .pwr_req    (pwr_req),
    .pwr_target (pwr_target)
  );

  dpc_arm_reg u_arm (
    .clk  (clk),
    .rst  (rst),
    .clr  (link_edge),
    .wr   (wr_arm),
    .wdata(cmd_payload[ARM_W-1:0]),
    .arm_q(arm_q)
  );

  dpc_state_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .clr       (link_edge),
    .pwr_req   (pwr_req),
    .pwr_target(pwr_target),
    .arm       (arm_q),
    .state_q   (state_q)
  );

  dpc_out_gate #(.RSP_W(RSP_W)) u_out (
    .clk      (clk),
    .rst      (rst),
    .state    (state_q),
    .rd_arm   (rd_arm),
    .arm      (arm_q),
    .en_q     (en_q),
    .rsp_valid(rsp_valid),
    .rsp_data (rsp_data)
  );

  assign pwr_state   = state_q;
  assign en_link     = en_q[3];
  assign en_gpio     = en_q[2];
  assign en_vref_amp = en_q[1];
  assign en_hp_amp   = en_q[0];
endmodule

// File: rtl/dpc_checker.sv
module dpc_checker
  import dpc_pkg::*;
#(
  parameter int RSP_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             link_rst_in,
  input logic             cmd_valid,
  input logic [7:0]       cmd_nid,
  input logic [11:0]      cmd_verb,
  input logic [7:0]       cmd_payload,
  input logic [1:0]       arm_q,
  input logic [2:0]       pwr_state,
  input logic             rsp_valid,
  input logic [RSP_W-1:0] rsp_data,
  input logic             en_link,
  input logic             en_gpio,
  input logic             en_vref_amp,
  input logic             en_hp_amp
);
  logic deep;
  logic d3c_req;
  assign deep    = (pwr_state == 3'd5) || (pwr_state == 3'd6);
  assign d3c_req = cmd_valid && (cmd_nid == 8'h01) && (cmd_verb == 12'h705)
                   && (cmd_payload == 8'd4);

  // R1
  a_r1_rsp_upper_zero: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_data[RSP_W-1:2] == '0));

  // R6
  a_r6_no_rsp_in_deep: assert property (@(posedge clk) disable iff (rst)
    deep |=> !rsp_valid);

  // R6
  a_r6_deep_holds: assert property (@(posedge clk) disable iff (rst)
    (deep && !link_rst_in) |=> $stable(pwr_state) && $stable(arm_q));

  // R4
  a_r4_d5_wins: assert property (@(posedge clk) disable iff (rst)
    (d3c_req && !deep && !link_rst_in && arm_q[1]) |=> (pwr_state == 3'd6));

  // R7
  a_r7_link_edge_exit: assert property (@(posedge clk) disable iff (rst)
    $rose(link_rst_in) |=> (pwr_state == 3'd4) && (arm_q == 2'b00));

  // R9
  a_r9_d5_all_off: assert property (@(posedge clk) disable iff (rst)
    (pwr_state == 3'd6) |=> !en_link && !en_gpio && !en_vref_amp && !en_hp_amp);

  // R9
  a_r9_d4_link_off: assert property (@(posedge clk) disable iff (rst)
    (pwr_state == 3'd5) |=> !en_link && en_gpio && en_vref_amp && en_hp_amp);

  // R9
  a_r9_shallow_all_on: assert property (@(posedge clk) disable iff (rst)
    !deep |=> en_link && en_gpio && en_vref_amp && en_hp_amp);
endmodule

bind deep_pwr_ctl dpc_checker #(.RSP_W(RSP_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .link_rst_in(link_rst_in),
  .cmd_valid  (cmd_valid),
  .cmd_nid    (cmd_nid),
  .cmd_verb   (cmd_verb),
  .cmd_payload(cmd_payload),
  .arm_q      (arm_q),
  .pwr_state  (pwr_state),
  .rsp_valid  (rsp_valid),
  .rsp_data   (rsp_data),
  .en_link    (en_link),
  .en_gpio    (en_gpio),
  .en_vref_amp(en_vref_amp),
  .en_hp_amp  (en_hp_amp)
);

// File: tb/deep_pwr_ctl_tb.sv
module deep_pwr_ctl_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        link_rst_in = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [7:0]  cmd_nid = '0;
  logic [11:0] cmd_verb = '0;
  logic [7:0]  cmd_payload = '0;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic [2:0]  pwr_state;
  logic        en_link, en_gpio, en_vref_amp, en_hp_amp;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [2:0] ms;
  logic [1:0] marm;

  always #(CLK_PERIOD/2) clk = ~clk;

  deep_pwr_ctl u_dut (
    .clk(clk), .rst(rst), .link_rst_in(link_rst_in),
    .cmd_valid(cmd_valid), .cmd_nid(cmd_nid), .cmd_verb(cmd_verb),
    .cmd_payload(cmd_payload), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .pwr_state(pwr_state), .en_link(en_link), .en_gpio(en_gpio),
    .en_vref_amp(en_vref_amp), .en_hp_amp(en_hp_amp)
  );

  function automatic logic [3:0] exp_en(logic [2:0] s);
    if (s == 3'd5) return 4'b0111;
    if (s == 3'd6) return 4'b0000;
    return 4'b1111;
  endfunction

  function automatic bit is_deep_m(logic [2:0] s);
    return (s == 3'd5) || (s == 3'd6);
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic chk_en(string req);
    chk({en_link, en_gpio, en_vref_amp, en_hp_amp} == exp_en(ms), req,
        {28'd0, en_link, en_gpio, en_vref_amp, en_hp_amp}, {28'd0, exp_en(ms)});
  endtask

  // Issues one command, updates the model, checks state, response and enables.
  task automatic do_cmd(logic [7:0] nid, logic [11:0] verb, logic [7:0] pay, string req);
    bit exp_rsp;
    logic [1:0] rd_val;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_nid = nid; cmd_verb = verb; cmd_payload = pay;
    exp_rsp = 1'b0;
    rd_val  = marm;
    if (!is_deep_m(ms) && nid == 8'h01) begin
      if (verb == 12'h7D8) marm = pay[1:0];
      if (verb == 12'hFD8) exp_rsp = 1'b1;
      if (verb == 12'h705 && pay <= 8'd4) begin
        if (pay == 8'd4) ms = marm[1] ? 3'd6 : (marm[0] ? 3'd5 : 3'd4);
        else             ms = pay[2:0];
      end
    end
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(pwr_state == ms, req, {29'd0, pwr_state}, {29'd0, ms});
    chk(rsp_valid == exp_rsp, req, {31'd0, rsp_valid}, {31'd0, exp_rsp});
    if (exp_rsp) chk(rsp_data == {30'd0, rd_val}, req, rsp_data, {30'd0, rd_val});
    @(negedge clk);
    chk_en(req);
  endtask

  task automatic link_pulse(string req);
    @(negedge clk);
    link_rst_in = 1'b1;
    ms = 3'd4; marm = 2'b00;
    @(negedge clk);
    chk(pwr_state == 3'd4, req, {29'd0, pwr_state}, 32'd4);
    @(negedge clk);
    link_rst_in = 1'b0;
    @(negedge clk);
    chk_en(req);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    total++; bad++;
    $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
    finish_run();
  end

  initial begin
    void'($urandom(32'd2741));
    ms = 3'd4; marm = 2'b00;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R8 reset state
    chk(pwr_state == 3'd4, "R8", {29'd0, pwr_state}, 32'd4);
    chk(!rsp_valid, "R8", {31'd0, rsp_valid}, 32'd0);
    chk_en("R8");
    do_cmd(8'h01, 12'hFD8, 8'h00, "R8 arm clear");

    // R2 / R1: upper payload ignored, read back
    do_cmd(8'h01, 12'h7D8, 8'hFE, "R2");
    do_cmd(8'h01, 12'hFD8, 8'h00, "R1");
    do_cmd(8'h02, 12'h7D8, 8'h01, "R2 other node");
    do_cmd(8'h01, 12'hFD8, 8'h00, "R2 other node");
    do_cmd(8'h03, 12'hFD8, 8'h00, "R1 other node");

    // R3
    do_cmd(8'h01, 12'h705, 8'h00, "R3");
    do_cmd(8'h01, 12'h705, 8'h05, "R3 ignore");
    do_cmd(8'h01, 12'h705, 8'h02, "R3");

    // R4: both armed -> D5
    do_cmd(8'h01, 12'h7D8, 8'h03, "R4");
    do_cmd(8'h01, 12'h705, 8'h04, "R4");
    do_cmd(8'h01, 12'hFD8, 8'h00, "R6");
    do_cmd(8'h01, 12'h705, 8'h00, "R6");
    link_pulse("R7");
    do_cmd(8'h01, 12'hFD8, 8'h00, "R7 arm clear");

    // R5
    do_cmd(8'h01, 12'h7D8, 8'h01, "R5");
    do_cmd(8'h01, 12'h705, 8'h04, "R5");
    do_cmd(8'h01, 12'h7D8, 8'h02, "R6");
    link_pulse("R7");
    do_cmd(8'h01, 12'h705, 8'h04, "R5 plain");

    // R10: arm while already in D3cold
    do_cmd(8'h01, 12'h7D8, 8'h02, "R10");
    do_cmd(8'h01, 12'hFD8, 8'h00, "R10");

    // R8 mid-run reset
    do_cmd(8'h01, 12'h705, 8'h01, "R3");
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    ms = 3'd4; marm = 2'b00;
    chk(pwr_state == 3'd4, "R8", {29'd0, pwr_state}, 32'd4);
    chk_en("R8");
    do_cmd(8'h01, 12'hFD8, 8'h00, "R8 arm clear");

    // Random mix
    for (int i = 0; i < 400; i++) begin
      int k;
      k = $urandom % 10;
      case (k)
        0, 1, 2: do_cmd(8'h01, 12'h7D8, 8'($urandom), "R2 rnd");
        3, 4:    do_cmd(8'h01, 12'hFD8, 8'($urandom), "R1 rnd");
        5, 6:    do_cmd(8'h01, 12'h705, 8'($urandom % 6), "R3 rnd");
        7:       do_cmd(8'($urandom % 4), 12'h7D8 | 12'(($urandom % 2) << 11),
                        8'($urandom), "R2 rnd nid");
        8:       link_pulse("R7 rnd");
        default: do_cmd(8'h01, 12'h705, 8'h04, "R4 R5 rnd");
      endcase
    end
    finish_run();
  end
endmodule